// File: doc/BRIEF.md
# Closed-Loop Power-Up Cascade Sequencer

This block turns on three downstream regulators one at a time. Each regulator has an active-low enable output. Each enable waits for two things: the rail that gates its step must be reported valid by its comparator flag, and a programmed delay must then run out. The sequence is not a fixed time schedule. The delay for a step counts only while that step's gating rail stays valid. Rail 0 gates the first enable, rail 1 the second and rail 2 the third.

The delays are counted in pulses of a millisecond tick input. A 2-bit code per step selects none, one, two or four base units, and the base unit is a parameter in ticks. A manual-reset request pauses the sequence. The reset generator can claim the shared timer, which pauses it in the same way. In both cases the sequence resumes from the same step and count when the hold ends. A configuration bit turns the whole sequence off and keeps every enable deasserted.

Top module: `cascade_seq`

## Requirements
- R1: Enables assert strictly in order: enN[1] never asserts while enN[0] is high, and enN[2] never asserts while enN[1] is high.
- R2: The step that drives enN[i] makes no progress while railOk[i] is 0, however many ticks arrive. Its enable stays high.
- R3: A step code of 2'b00 gives no delay. Codes 2'b01, 2'b10 and 2'b11 give 1, 2 and 4 base units. A base unit is UNIT_MS ticks, so the default of 25 gives 25, 50 and 100 ms.
- R4: delayCode[1:0] sets the step for enN[0], delayCode[3:2] the step for enN[1], and delayCode[5:4] the step for enN[2].
- R5: Each step with a nonzero target of T ticks counts the msTick pulses it samples while its gating rail is valid. Its enable falls at the clock edge after the edge that samples the T-th such pulse. With a zero target, the enable falls at the first edge that samples the gating rail valid while that step is current.
- R6: While cascadeOff is 1, all enables are high one edge later and the sequence returns to its first step. When cascadeOff returns to 0, the sequence starts again from the first step.
- R7: While pauseReq is 1, the step and its tick count are frozen. After release, counting continues from the frozen value and does not restart.
- R8: timerClaim has the same freezing effect as pauseReq and has priority over the sequencer's use of the timer.
- R9: An asserted enable stays low when its gating rail later drops. Only cascadeOff or reset deasserts it.
- R10: If the gating rail drops before the step's delay has run out, that step's tick count clears. The full delay is then counted again once the rail is valid.
- R11: step equals the number of asserted enables. busy is 1 while cascadeOff is 0 and fewer than three enables are asserted.
- R12: After reset, all enables are high and step is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| railOk | input | STEPS | Per-rail above-threshold flags, bit i gates enN[i] |
| cascadeOff | input | 1 | 1 disables sequencing and deasserts all enables |
| delayCode | input | 2*STEPS | Packed 2-bit delay codes, one per step |
| pauseReq | input | 1 | Manual-reset request; freezes the sequence |
| timerClaim | input | 1 | Reset generator claims the shared timer; freezes the sequence |
| msTick | input | 1 | One-cycle millisecond tick pulse |
| enN | output | STEPS | Active-low regulator enables |
| busy | output | 1 | Sequence enabled and not yet complete |
| step | output | $clog2(STEPS+1) | Current step, equal to the number of enables asserted |

## Verification
The hardest situation to reach from the ports is a partial tick count that must survive some disturbance. Three disturbances matter. Under a pause or a timer claim, the count must be kept. Under a brief loss of the gating rail, it must be thrown away.

The stimulus drives ticks one at a time as single-cycle pulses. It stops part way through a delay, then applies the disturbance for many tick periods or for a single cycle. It then counts the remaining ticks exactly, so that an enable falling one tick early or one tick late shows up.

A sweep over all 64 delay-field values checks every code in every step position, using a two-tick base unit.

// File: rtl/cascade_pkg.sv
`timescale 1ns/1ps
package cascade_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic clear;    // zero the step tick counter
    logic inc;      // count one tick
    logic advance;  // assert the current step's enable
    logic allOff;   // force every enable high
  } seqStrobe_t;
endpackage

// File: rtl/cascade_ctrl.sv
`timescale 1ns/1ps
module cascade_ctrl
  import cascade_pkg::*;
#(
  parameter int STEPS = 3,
  localparam int STEP_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STEPS-1:0]  railOk,
  input  logic              cascadeOff,
  input  logic              holdReq,
  input  logic              msTick,
  input  logic              reached,
  output seqStrobe_t        strobe,
  output logic [STEP_W-1:0] step,
  output logic              busy
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS);

  logic active;
  logic gateOk;

  assign active = (step != LAST);

  always_comb begin
    gateOk = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (step == STEP_W'(i)) gateOk = railOk[i];
    end
  end

  // Hold freezes everything, including the clear on rail loss
  always_comb begin
    strobe = '0;
    if (cascadeOff) begin
      strobe.allOff = 1'b1;
      strobe.clear  = 1'b1;
    end else if (active && !holdReq) begin
      if (!gateOk) begin
        strobe.clear = 1'b1;
      end else if (reached) begin
        strobe.advance = 1'b1;
        strobe.clear   = 1'b1;
      end else if (msTick) begin
        strobe.inc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                step <= '0;
    else if (strobe.allOff)   step <= '0;
    else if (strobe.advance)  step <= step + 1'b1;
  end

  assign busy = !cascadeOff && active;
endmodule

// File: rtl/cascade_dp.sv
`timescale 1ns/1ps
module cascade_dp
  import cascade_pkg::*;
#(
  parameter int STEPS   = 3,
  parameter int UNIT_MS = 25,
  localparam int STEP_W = $clog2(STEPS + 1),
  localparam int MAX_T  = 4 * UNIT_MS,
  localparam int CNT_W  = $clog2(MAX_T + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2*STEPS-1:0]   delayCode,
  input  logic [STEP_W-1:0]    step,
  input  seqStrobe_t           strobe,
  output logic                 reached,
  output logic [STEPS-1:0]     enN
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tgt [STEPS];
  logic [CNT_W-1:0] selTgt;

  for (genvar g = 0; g < STEPS; g++) begin : g_lane
    logic [1:0] code;
    assign code = delayCode[2*g +: 2];

    always_comb begin
      unique case (code)
        2'b00:   tgt[g] = '0;
        2'b01:   tgt[g] = CNT_W'(UNIT_MS);
        2'b10:   tgt[g] = CNT_W'(2 * UNIT_MS);
        default: tgt[g] = CNT_W'(4 * UNIT_MS);
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       enN[g] <= 1'b1;
      else if (strobe.allOff)                          enN[g] <= 1'b1;
      else if (strobe.advance && step == STEP_W'(g))   enN[g] <= 1'b0;
    end
  end

  always_comb begin
    selTgt = '0;
    for (int i = 0; i < STEPS; i++) begin
      if (step == STEP_W'(i)) selTgt = tgt[i];
    end
  end

  assign reached = (cnt >= selTgt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strobe.clear) cnt <= '0;
    else if (strobe.inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cascade_seq.sv
`timescale 1ns/1ps
module cascade_seq
  import cascade_pkg::*;
#(
  parameter int STEPS   = 3,
  parameter int UNIT_MS = 25,
  localparam int STEP_W = $clog2(STEPS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STEPS-1:0]   railOk,
  input  logic               cascadeOff,
  input  logic [2*STEPS-1:0] delayCode,
  input  logic               pauseReq,
  input  logic               timerClaim,
  input  logic               msTick,
  output logic [STEPS-1:0]   enN,
  output logic               busy,
  output logic [STEP_W-1:0]  step
);
  seqStrobe_t strobe;
  logic reached;
  logic holdReq;

  assign holdReq = pauseReq | timerClaim;

  cascade_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .railOk(railOk), .cascadeOff(cascadeOff),
    .holdReq(holdReq), .msTick(msTick), .reached(reached),
    .strobe(strobe), .step(step), .busy(busy)
  );

  cascade_dp #(.STEPS(STEPS), .UNIT_MS(UNIT_MS)) u_dp (
    .clk(clk), .rstN(rstN), .delayCode(delayCode), .step(step),
    .strobe(strobe), .reached(reached), .enN(enN)
  );
endmodule

// File: rtl/cascade_seq_chk.sv
`timescale 1ns/1ps
module cascade_seq_chk #(
  parameter int STEPS = 3,
  localparam int STEP_W = $clog2(STEPS + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic [STEPS-1:0]   railOk,
  input logic               cascadeOff,
  input logic               pauseReq,
  input logic               timerClaim,
  input logic [STEPS-1:0]   enN,
  input logic [STEP_W-1:0]  step
);
  for (genvar g = 0; g < STEPS; g++) begin : g_lane
    // R9: an asserted enable remains asserted
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
      (!enN[g] && !cascadeOff) |=> !enN[g]);
    // R2: an enable only falls after its gating rail was sampled valid
    p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
      $fell(enN[g]) |-> $past(railOk[g]));
    if (g > 0) begin : g_ord
      // R1: order is fixed
      p_order_r1: assert property (@(posedge clk) disable iff (!rstN)
        !enN[g] |-> !enN[g-1]);
    end
  end

  // R7 / R8: a hold freezes outputs and step
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((pauseReq || timerClaim) && !cascadeOff) |=> ($stable(enN) && $stable(step)));

  // R6: disable forces all enables high and step back to zero
  p_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    cascadeOff |=> (enN == '1 && step == '0));

  // R11: step tracks asserted enables
  p_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~enN) == int'(step));
endmodule

bind cascade_seq cascade_seq_chk #(.STEPS(STEPS)) u_chk (
  .clk(clk), .rstN(rstN), .railOk(railOk), .cascadeOff(cascadeOff),
  .pauseReq(pauseReq), .timerClaim(timerClaim), .enN(enN), .step(step)
);

// File: tb/sim_cascade_seq.sv
`timescale 1ns/1ps
module sim_cascade_seq;
  localparam int UNIT = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] railOk = 3'b000;
  logic       cascadeOff = 1'b0;
  logic [5:0] delayCode = 6'd0;
  logic       pauseReq = 1'b0;
  logic       timerClaim = 1'b0;
  logic       msTick = 1'b0;
  logic [2:0] enN;
  logic       busy;
  logic [1:0] step;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_seq #(.STEPS(3), .UNIT_MS(UNIT)) u0 (
    .clk(clk), .rstN(rstN), .railOk(railOk), .cascadeOff(cascadeOff),
    .delayCode(delayCode), .pauseReq(pauseReq), .timerClaim(timerClaim),
    .msTick(msTick), .enN(enN), .busy(busy), .step(step)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // one tick pulse followed by one idle cycle
  task automatic tick(input int n);
    repeat (n) begin
      msTick = 1'b1;
      @(posedge clk); @(negedge clk);
      msTick = 1'b0;
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic doReset(input logic [5:0] d, input logic [2:0] rails, input logic off);
    rstN = 1'b0; delayCode = d; railOk = rails; cascadeOff = off;
    pauseReq = 1'b0; timerClaim = 1'b0; msTick = 1'b0;
    cyc(2);
    rstN = 1'b1;
  endtask

  function automatic int tgtOf(input int d, input int s);
    int code;
    code = (d >> (2 * s)) & 3;
    return (code == 0) ? 0 : (1 << (code - 1)) * UNIT;
  endfunction

  initial begin
    @(negedge clk);
    // R12: reset state
    doReset(6'd0, 3'b000, 1'b0);
    chk(enN == 3'b111, "R12 enN", enN, 7);
    chk(step == 2'd0, "R12 step", step, 0);

    // R3/R4/R5 sweep over every delay field value
    for (int d = 0; d < 64; d++) begin
      doReset(6'(d), 3'b111, 1'b0);
      for (int s = 0; s < 3; s++) begin
        int t;
        t = tgtOf(d, s);
        if (t == 0) begin
          cyc(1);
          chk(enN[s] == 1'b0, "R3 zero delay enable", enN[s], 0);
        end else begin
          tick(t - 1);
          chk(enN[s] == 1'b1, "R4 early enable", enN[s], 1);
          tick(1);
          chk(enN[s] == 1'b0, "R5 enable after target", enN[s], 0);
        end
        chk(int'(step) == s + 1, "R11 step", step, s + 1);
      end
    end

    // R2 gating, R1 order, R9 sticky, R11 busy
    doReset(6'b000011, 3'b000, 1'b0);
    tick(20);
    chk(enN == 3'b111, "R2 no rail no enable", enN, 7);
    railOk = 3'b001;
    tick(7);
    chk(enN[0] == 1'b1, "R2 count starts at rail valid", enN[0], 1);
    tick(1);
    chk(enN[0] == 1'b0, "R2 enable after rail valid", enN[0], 0);
    cyc(3);
    chk(enN[1] == 1'b1, "R1 step two waits rail1", enN[1], 1);
    railOk = 3'b011;
    cyc(1);
    chk(enN == 3'b100, "R1 enable two", enN, 4);
    railOk = 3'b111;
    cyc(1);
    chk(enN == 3'b000, "R1 enable three", enN, 0);
    chk(busy == 1'b0, "R11 busy done", busy, 0);
    railOk = 3'b000;
    cyc(3);
    chk(enN == 3'b000, "R9 sticky after rail loss", enN, 0);

    // R10 rail drop clears count
    doReset(6'b000011, 3'b001, 1'b0);
    tick(5);
    railOk = 3'b000;
    cyc(1);
    railOk = 3'b001;
    tick(7);
    chk(enN[0] == 1'b1, "R10 count restarted", enN[0], 1);
    tick(1);
    chk(enN[0] == 1'b0, "R10 full delay recounted", enN[0], 0);

    // R7 pause resumes
    doReset(6'b000011, 3'b001, 1'b0);
    tick(3);
    pauseReq = 1'b1;
    tick(10);
    chk(enN[0] == 1'b1, "R7 frozen during pause", enN[0], 1);
    chk(busy == 1'b1, "R11 busy during pause", busy, 1);
    pauseReq = 1'b0;
    tick(4);
    chk(enN[0] == 1'b1, "R7 resume not early", enN[0], 1);
    tick(1);
    chk(enN[0] == 1'b0, "R7 resume from count", enN[0], 0);

    // R8 timer claim resumes
    doReset(6'b001100, 3'b011, 1'b0);
    cyc(1);
    chk(enN == 3'b110, "R8 first step zero delay", enN, 6);
    tick(5);
    timerClaim = 1'b1;
    tick(9);
    chk(enN[1] == 1'b1, "R8 frozen during claim", enN[1], 1);
    timerClaim = 1'b0;
    tick(2);
    chk(enN[1] == 1'b1, "R8 resume not early", enN[1], 1);
    tick(1);
    chk(enN[1] == 1'b0, "R8 resume from count", enN[1], 0);

    // R6 cascade off
    doReset(6'd0, 3'b111, 1'b1);
    cyc(10);
    chk(enN == 3'b111, "R6 off keeps high", enN, 7);
    chk(busy == 1'b0, "R11 busy off", busy, 0);
    cascadeOff = 1'b0;
    cyc(3);
    chk(enN == 3'b000, "R6 runs when enabled", enN, 0);
    cascadeOff = 1'b1;
    cyc(1);
    chk(enN == 3'b111, "R6 off deasserts", enN, 7);
    chk(step == 2'd0, "R6 step back to start", step, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule